// File: doc/BRIEF.md
# Flash Erase Control Register Front-End

This block is the register-facing half of a serial flash controller. Software writes a single operation register to arm, erase or protect. The block guards each modifying action behind a write-enable latch. That latch must be set by an earlier write of its own. The block also keeps a per-sector protection bitmap. It refuses any erase that would touch a protected region, and records the refusal in a write-one-to-clear interrupt status bit.

Accepted erases go to a downstream flash command engine over a valid/ready request and a done pulse. Between the request and the done pulse, a busy flag is readable and further operation writes are dropped. Reads are combinational and complete in the cycle they are presented. Writes take effect on the next rising clock edge.

Top module: `flash_op_regs`

## Requirements
- R1: After reset, every readable register reads 0, `eng_valid` is low and `irq` is low.
- R2: A write to offset 0x0 with code 00 in bits 1:0 and bit 3 set sets the write-enable latch, which reads back as bit 1 of the status register (offset 0x4). A write that carries a nonzero code never sets the latch, even when bit 3 is 1.
- R3: A bulk-erase (01), sector-erase (10) or protect (11) code written while the latch is clear is ignored: no request is issued and no state changes.
- R4: A sector erase (code 10) with the latch set, to an unprotected sector, raises `eng_valid` on the next cycle with `eng_bulk`=0 and `eng_sector` equal to bits 23:8 of the write, and clears the latch.
- R5: A bulk erase (code 01) with the latch set issues a request with `eng_bulk`=1 when no protection bit is set. If any protection bit is set, it is illegal instead.
- R6: A protect command (code 11) with the latch set writes bit 4 of the same write into protection bit N, where N is the low 4 bits of the sector field. Bit 4 = 1 protects and bit 4 = 0 unprotects. The bitmap reads back at status bits 31:16 (bit 16+N), and the command clears the latch.
- R7: A sector erase with the latch set whose sector maps to a protected bit issues no request. It sets the illegal-erase bit (bit 0 at offset 0x8) and clears the latch.
- R8: Writing 1 to bit 0 of offset 0x8 clears the illegal-erase bit. Writing 0 leaves it unchanged.
- R9: `irq` is high exactly when the illegal-erase bit and mask bit 0 (offset 0xC, read/write) are both 1.
- R10: Status bit 0 (busy) reads 1 from the cycle `eng_valid` first rises until the cycle after `eng_done`. `eng_valid` and `eng_sector` hold until `eng_ready` is seen. Operation writes while busy are ignored.
- R11: Offsets outside 0x0–0xC read 0 and writes to them change nothing. Offset 0x0 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (5) | Byte offset |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid in the strobe cycle |
| eng_valid | output | 1 | Erase request to the command engine |
| eng_ready | input | 1 | Engine accepts the request |
| eng_bulk | output | 1 | 1 = bulk erase, 0 = sector erase |
| eng_sector | output | SEC_W (16) | Sector number of the request |
| eng_done | input | 1 | Engine finished the erase (pulse) |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults: a 16-bit sector field, a 16-entry protection bitmap and a 5-bit offset. With these values the whole bitmap is visible in the upper half of the status word. Sector 0x0013 aliases onto protection bit 3, so the index truncation can be checked. Offsets 0x10–0x1C exist on the bus and are not mapped, which makes the read-zero and write-ignore behaviour reachable. A stub engine delays `eng_ready` and `eng_done` by several cycles, which exposes the request hold and the busy window.

// File: rtl/flash_op_pkg.sv
package flash_op_pkg;

    typedef enum logic [1:0] {
        OP_NONE    = 2'b00,
        OP_BULK    = 2'b01,
        OP_SECTOR  = 2'b10,
        OP_PROTECT = 2'b11
    } op_code_e;

    typedef enum logic [1:0] {
        SEL_OP   = 2'd0,
        SEL_STAT = 2'd1,
        SEL_ISR  = 2'd2,
        SEL_MASK = 2'd3
    } reg_sel_e;

    // field positions inside the operation word
    localparam int unsigned WEN_BIT   = 3;
    localparam int unsigned PSET_BIT  = 4;
    localparam int unsigned SEC_LSB   = 8;
    // status word layout
    localparam int unsigned ST_BUSY   = 0;
    localparam int unsigned ST_WEL    = 1;
    localparam int unsigned ST_PROT   = 16;

endpackage

// File: rtl/op_sequencer.sv
module op_sequencer
    import flash_op_pkg::*;
#(
    parameter int unsigned SEC_W  = 16,
    parameter int unsigned PROT_N = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_wr,
    input  op_code_e          cmd,
    input  logic              wen,
    input  logic              pset,
    input  logic [SEC_W-1:0]  sector,
    input  logic              busy,
    output logic              wel,
    output logic [PROT_N-1:0] prot,
    output logic              issue,
    output logic              issue_bulk,
    output logic              illegal
);
    localparam int unsigned IDX_W = (PROT_N > 1) ? $clog2(PROT_N) : 1;

    typedef struct packed {
        logic              wel;
        logic [PROT_N-1:0] prot;
    } seq_t;

    seq_t s_d, s_q;
    logic [IDX_W-1:0] idx;

    assign idx = sector[IDX_W-1:0];

    always_comb begin
        s_d        = s_q;
        issue      = 1'b0;
        issue_bulk = 1'b0;
        illegal    = 1'b0;
        if (op_wr && !busy) begin
            case (cmd)
                OP_NONE: begin
                    if (wen) s_d.wel = 1'b1;
                end
                OP_SECTOR: begin
                    if (s_q.wel) begin
                        s_d.wel = 1'b0;
                        if (s_q.prot[idx]) illegal = 1'b1;
                        else               issue   = 1'b1;
                    end
                end
                OP_BULK: begin
                    if (s_q.wel) begin
                        s_d.wel = 1'b0;
                        if (|s_q.prot) begin
                            illegal = 1'b1;
                        end else begin
                            issue      = 1'b1;
                            issue_bulk = 1'b1;
                        end
                    end
                end
                OP_PROTECT: begin
                    if (s_q.wel) begin
                        s_d.wel       = 1'b0;
                        s_d.prot[idx] = pset;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wel  = s_q.wel;
    assign prot = s_q.prot;

    p_latch_from_plain_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.wel) |-> $past(op_wr) && $past(cmd) == OP_NONE);

    p_no_action_unarmed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.wel) |-> !issue && !illegal);

    p_latch_drops_on_issue_r4: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> !s_q.wel);

    p_latch_drops_on_illegal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> !s_q.wel);

    p_busy_freezes_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_wr && busy) |=> $stable(s_q));

endmodule

// File: rtl/req_port.sv
module req_port #(
    parameter int unsigned SEC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic             issue_bulk,
    input  logic [SEC_W-1:0] issue_sector,
    input  logic             eng_ready,
    input  logic             eng_done,
    output logic             eng_valid,
    output logic             eng_bulk,
    output logic [SEC_W-1:0] eng_sector,
    output logic             busy
);
    typedef struct packed {
        logic             pend;
        logic             busy;
        logic             bulk;
        logic [SEC_W-1:0] sector;
    } req_t;

    req_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (issue) begin
            r_d.pend   = 1'b1;
            r_d.busy   = 1'b1;
            r_d.bulk   = issue_bulk;
            r_d.sector = issue_sector;
        end else begin
            if (r_q.pend && eng_ready) r_d.pend = 1'b0;
            if (r_q.busy && !r_q.pend && eng_done) r_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign eng_valid  = r_q.pend;
    assign eng_bulk   = r_q.bulk;
    assign eng_sector = r_q.sector;
    assign busy       = r_q.busy;

    p_hold_until_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_valid && !eng_ready) |=> eng_valid && $stable(eng_sector) && $stable(eng_bulk));

    p_valid_inside_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        eng_valid |-> busy);

    p_issue_raises_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> eng_valid);

endmodule

// File: rtl/int_regs.sv
module int_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic illegal,
    input  logic isr_wr,
    input  logic mask_wr,
    input  logic wbit,
    output logic isr,
    output logic mask,
    output logic irq
);
    typedef struct packed {
        logic isr;
        logic mask;
    } ir_t;

    ir_t i_d, i_q;

    always_comb begin
        i_d = i_q;
        if (isr_wr && wbit) i_d.isr = 1'b0;
        if (illegal)        i_d.isr = 1'b1;   // a new event wins over a clear
        if (mask_wr)        i_d.mask = wbit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) i_q <= '0;
        else        i_q <= i_d;
    end

    assign isr  = i_q.isr;
    assign mask = i_q.mask;
    assign irq  = i_q.isr & i_q.mask;

    p_illegal_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> isr);

    p_one_clears_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_wr && wbit && !illegal) |=> !isr);

    p_zero_keeps_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (isr && isr_wr && !wbit) |=> isr);

    p_masked_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mask |-> !irq);

endmodule

// File: rtl/flash_op_regs.sv
module flash_op_regs
    import flash_op_pkg::*;
#(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SEC_W  = 16,
    parameter int unsigned PROT_N = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              eng_valid,
    input  logic              eng_ready,
    output logic              eng_bulk,
    output logic [SEC_W-1:0]  eng_sector,
    input  logic              eng_done,
    output logic              irq
);
    logic              mapped;
    reg_sel_e          sel;
    logic              op_wr, isr_wr, mask_wr;
    logic              wel, busy, issue, issue_bulk, illegal, isr, mask;
    logic [PROT_N-1:0] prot;
    logic [DATA_W-1:0] stat_word;
    logic              unused_wdata;

    assign unused_wdata = ^bus_wdata;

    assign mapped  = (bus_addr[ADDR_W-1:4] == '0);
    assign sel     = reg_sel_e'(bus_addr[3:2]);
    assign op_wr   = bus_wr && mapped && (sel == SEL_OP);
    assign isr_wr  = bus_wr && mapped && (sel == SEL_ISR);
    assign mask_wr = bus_wr && mapped && (sel == SEL_MASK);

    op_sequencer #(.SEC_W(SEC_W), .PROT_N(PROT_N)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_wr      (op_wr),
        .cmd        (op_code_e'(bus_wdata[1:0])),
        .wen        (bus_wdata[WEN_BIT]),
        .pset       (bus_wdata[PSET_BIT]),
        .sector     (bus_wdata[SEC_LSB +: SEC_W]),
        .busy       (busy),
        .wel        (wel),
        .prot       (prot),
        .issue      (issue),
        .issue_bulk (issue_bulk),
        .illegal    (illegal)
    );

    req_port #(.SEC_W(SEC_W)) u_req (
        .clk          (clk),
        .rst_n        (rst_n),
        .issue        (issue),
        .issue_bulk   (issue_bulk),
        .issue_sector (bus_wdata[SEC_LSB +: SEC_W]),
        .eng_ready    (eng_ready),
        .eng_done     (eng_done),
        .eng_valid    (eng_valid),
        .eng_bulk     (eng_bulk),
        .eng_sector   (eng_sector),
        .busy         (busy)
    );

    int_regs u_int (
        .clk     (clk),
        .rst_n   (rst_n),
        .illegal (illegal),
        .isr_wr  (isr_wr),
        .mask_wr (mask_wr),
        .wbit    (bus_wdata[0]),
        .isr     (isr),
        .mask    (mask),
        .irq     (irq)
    );

    always_comb begin
        stat_word                   = '0;
        stat_word[ST_BUSY]          = busy;
        stat_word[ST_WEL]           = wel;
        stat_word[ST_PROT +: PROT_N] = prot;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd && mapped) begin
            case (sel)
                SEL_STAT: bus_rdata = stat_word;
                SEL_ISR:  bus_rdata[0] = isr;
                SEL_MASK: bus_rdata[0] = mask;
                default:  bus_rdata = '0;
            endcase
        end
    end

    p_unmapped_inert_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !mapped) |=> $stable(mask) && $stable(wel) && $stable(prot));

endmodule

// File: tb/tb_flash_op_regs.sv
module tb_flash_op_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        eng_valid, eng_bulk, irq;
    logic        eng_ready = 1'b0, eng_done = 1'b0;
    logic [15:0] eng_sector;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;   // 250 MHz

    flash_op_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_valid(eng_valid), .eng_ready(eng_ready), .eng_bulk(eng_bulk),
        .eng_sector(eng_sector), .eng_done(eng_done), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    // stub engine: accept after 2 idle cycles, finish after 3 more
    task automatic serve(input string req);
        logic [31:0] s;
        @(negedge clk);
        chk({req, " hold valid"}, {31'b0, eng_valid}, 32'h1);
        eng_ready = 1'b1;
        @(negedge clk);
        eng_ready = 1'b0;
        chk("R10 valid drops after ready", {31'b0, eng_valid}, 32'h0);
        rd(5'h04, s);
        chk("R10 busy until done", s & 32'h1, 32'h1);
        repeat (2) @(negedge clk);
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
        rd(5'h04, s);
        chk("R10 busy clears after done", s & 32'h1, 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(5'h04, v); chk("R1 status", v, 32'h0);
        rd(5'h08, v); chk("R1 isr", v, 32'h0);
        rd(5'h0C, v); chk("R1 mask", v, 32'h0);
        chk("R1 valid/irq", {30'b0, eng_valid, irq}, 32'h0);
    endtask

    task automatic t_unarmed();
        logic [31:0] v;
        wr(5'h00, 32'h0000_050A);   // bit3 + sector erase in one write
        chk("R2 combined write no erase", {31'b0, eng_valid}, 32'h0);
        rd(5'h04, v); chk("R2 combined write no latch", v, 32'h0);
        wr(5'h00, 32'h0000_0302);
        chk("R3 erase unarmed", {31'b0, eng_valid}, 32'h0);
        wr(5'h00, 32'h0000_0313);
        rd(5'h04, v); chk("R3 protect unarmed", v, 32'h0);
        wr(5'h00, 32'h0000_0001);
        chk("R3 bulk unarmed", {31'b0, eng_valid}, 32'h0);
        wr(5'h00, 32'h0000_0008);
        rd(5'h04, v); chk("R2 latch set", v, 32'h2);
    endtask

    task automatic t_sector_erase();
        logic [31:0] v;
        wr(5'h00, 32'h0012_3402);   // latch still armed from t_unarmed
        chk("R4 valid", {31'b0, eng_valid}, 32'h1);
        chk("R4 kind", {31'b0, eng_bulk}, 32'h0);
        chk("R4 sector", {16'b0, eng_sector}, 32'h1234);
        rd(5'h04, v); chk("R4 busy, latch cleared", v, 32'h1);
        @(negedge clk);
        chk("R10 sector stable", {16'b0, eng_sector}, 32'h1234);
        serve("R10");
    endtask

    task automatic t_busy_block();
        logic [31:0] v;
        wr(5'h00, 32'h0000_0008);
        wr(5'h00, 32'h0000_0702);
        wr(5'h00, 32'h0000_0008);   // while busy
        rd(5'h04, v); chk("R10 write ignored while busy", v, 32'h1);
        serve("R10");
        rd(5'h04, v); chk("R10 idle after", v, 32'h0);
    endtask

    task automatic t_protect_illegal();
        logic [31:0] v;
        wr(5'h00, 32'h0000_0008);
        wr(5'h00, 32'h0000_0313);   // protect sector 3
        rd(5'h04, v); chk("R6 bit set, latch cleared", v, 32'h0008_0000);
        wr(5'h00, 32'h0000_0008);
        wr(5'h00, 32'h0000_1302);   // sector 0x13 aliases to bit 3
        chk("R7 no request", {31'b0, eng_valid}, 32'h0);
        rd(5'h08, v); chk("R7 flag set", v, 32'h1);
        rd(5'h04, v); chk("R7 latch cleared", v, 32'h0008_0000);
        chk("R9 masked irq low", {31'b0, irq}, 32'h0);
        wr(5'h0C, 32'h1);
        chk("R9 irq high", {31'b0, irq}, 32'h1);
        wr(5'h08, 32'h0);
        rd(5'h08, v); chk("R8 zero keeps", v, 32'h1);
        wr(5'h08, 32'h1);
        rd(5'h08, v); chk("R8 one clears", v, 32'h0);
        chk("R9 irq low after clear", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_bulk();
        logic [31:0] v;
        wr(5'h00, 32'h0000_0008);
        wr(5'h00, 32'h0000_0001);
        chk("R5 bulk refused", {31'b0, eng_valid}, 32'h0);
        rd(5'h08, v); chk("R5 bulk illegal flag", v, 32'h1);
        chk("R9 irq on bulk illegal", {31'b0, irq}, 32'h1);
        wr(5'h08, 32'h1);
        wr(5'h00, 32'h0000_0008);
        wr(5'h00, 32'h0000_0303);   // unprotect sector 3
        rd(5'h04, v); chk("R6 bit cleared", v, 32'h0);
        wr(5'h00, 32'h0000_0008);
        wr(5'h00, 32'h0000_0001);
        chk("R5 bulk valid", {31'b0, eng_valid}, 32'h1);
        chk("R5 bulk kind", {31'b0, eng_bulk}, 32'h1);
        serve("R5");
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(5'h1C, 32'hFFFF_FFFF);
        wr(5'h10, 32'h0000_0008);
        rd(5'h1C, v); chk("R11 unmapped reads 0", v, 32'h0);
        rd(5'h0C, v); chk("R11 mask untouched", v, 32'h1);
        rd(5'h04, v); chk("R11 latch untouched", v, 32'h0);
        rd(5'h00, v); chk("R11 op reads 0", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unarmed();
        t_sector_erase();
        t_busy_block();
        t_protect_illegal();
        t_bulk();
        t_unmapped();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule